// File: doc/BRIEF.md
# Universal Shift Register with Shared Parallel Bus

This block is a WIDTH-bit storage register. A two-bit mode input selects one of four actions: keep the value, move the contents toward the most significant bit, move them toward the least significant bit, or capture a parallel word. The selected action happens on each rising clock edge. Each shift direction has its own serial input. The shared bidirectional pins are split into three signals: an input bus, an output bus and a single drive-enable flag. The pad ring or a wrapper combines them into tri-state pins.

The least and most significant bits also appear on two serial outputs. These outputs are always driven, so several registers can be chained into a longer word. The output enables do not affect them. An active-low master reset clears the register at once, without waiting for a clock. Its release passes through a synchronizer, so the first update after reset happens on a known edge.

Top module: `univ_shift_reg`

## Requirements
- R1: While rst_ni is low, the register reads all zeros on par_o. The clear takes effect without a clock edge and overrides mode_i.
- R2: After rst_ni rises, the register stays at zero through the first SYNC_STAGES rising edges. The first mode action takes effect on edge SYNC_STAGES+1.
- R3: With mode_i = 2'b00 (hold), the register keeps its value across a rising edge.
- R4: With mode_i = 2'b01, each bit n moves to bit n+1 on the edge and ser_up_i enters bit 0.
- R5: With mode_i = 2'b10, each bit n moves to bit n-1 on the edge and ser_dn_i enters bit WIDTH-1.
- R6: With mode_i = 2'b11, the register captures par_i on the edge.
- R7: par_oe_o is high only when oe_a_ni and oe_b_ni are both low and mode_i is not 2'b11. It follows its inputs combinationally. par_o always carries the register value.
- R8: ser_lsb_o equals bit 0 and ser_msb_o equals bit WIDTH-1 of the register for every setting of the enables.
- R9: Hold, shift, load and reset work the same way whether par_oe_o is high or low.
- R10: Two instances chained through ser_msb_o into ser_up_i behave as one 2*WIDTH-bit register shifting toward its upper end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Active-low master reset: clears at once, released synchronously |
| mode_i | input | 2 | 00 hold, 01 shift up, 10 shift down, 11 parallel load |
| ser_up_i | input | 1 | Serial bit entering bit 0 in shift-up mode |
| ser_dn_i | input | 1 | Serial bit entering bit WIDTH-1 in shift-down mode |
| oe_a_ni | input | 1 | Output enable A, active low |
| oe_b_ni | input | 1 | Output enable B, active low |
| par_i | input | WIDTH | Input side of the shared parallel pins |
| par_o | output | WIDTH | Output side of the shared parallel pins (register value) |
| par_oe_o | output | 1 | Drive enable for the shared parallel pins |
| ser_lsb_o | output | 1 | Bit 0, always driven |
| ser_msb_o | output | 1 | Bit WIDTH-1, always driven |

## Verification
The bench uses the default WIDTH of 8 and SYNC_STAGES of 2. At these values every start word can be combined with every mode and both serial bit values, and the enable pair cycles through all four settings along the way. That covers every register value and every drive-enable case. The two-stage synchronizer keeps the reset-release window short enough to test edge by edge. The 8-bit width lets a chained pair be followed through a full 16-bit shift-through.

// File: rtl/usr_pkg.sv
package usr_pkg;
  typedef enum logic [1:0] {
    MODE_HOLD = 2'b00,
    MODE_UP   = 2'b01,
    MODE_DN   = 2'b10,
    MODE_LOAD = 2'b11
  } usr_mode_e;
endpackage

// File: rtl/usr_rst_sync.sv
// Asynchronous assert, synchronous release; SYNC_STAGES must be >= 2.
module usr_rst_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [SYNC_STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[SYNC_STAGES-2:0], 1'b1};
  end

  assign rst_no = sync_q[SYNC_STAGES-1];
endmodule

// File: rtl/usr_next.sv
module usr_next
  import usr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  usr_mode_e        mode_i,
  input  logic [WIDTH-1:0] cur_i,
  input  logic             ser_up_i,
  input  logic             ser_dn_i,
  input  logic [WIDTH-1:0] par_i,
  output logic [WIDTH-1:0] nxt_o
);
  always_comb begin
    unique case (mode_i)
      MODE_HOLD: nxt_o = cur_i;
      MODE_UP:   nxt_o = {cur_i[WIDTH-2:0], ser_up_i};
      MODE_DN:   nxt_o = {ser_dn_i, cur_i[WIDTH-1:1]};
      default:   nxt_o = par_i;
    endcase
  end
endmodule

// File: rtl/usr_oe.sv
module usr_oe
  import usr_pkg::*;
(
  input  usr_mode_e mode_i,
  input  logic      oe_a_ni,
  input  logic      oe_b_ni,
  output logic      drive_o
);
  // Pins released in load mode so external data can be applied.
  logic load_sel;
  assign load_sel = (mode_i == MODE_LOAD);
  assign drive_o  = ~oe_a_ni & ~oe_b_ni & ~load_sel;
endmodule

// File: rtl/univ_shift_reg.sv
module univ_shift_reg
  import usr_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       mode_i,
  input  logic             ser_up_i,
  input  logic             ser_dn_i,
  input  logic             oe_a_ni,
  input  logic             oe_b_ni,
  input  logic [WIDTH-1:0] par_i,
  output logic [WIDTH-1:0] par_o,
  output logic             par_oe_o,
  output logic             ser_lsb_o,
  output logic             ser_msb_o
);
  localparam int MSB = WIDTH - 1;

  usr_mode_e        mode;
  logic             rst_int_n;
  logic [WIDTH-1:0] data_q;
  logic [WIDTH-1:0] data_d;

  assign mode = usr_mode_e'(mode_i);

  usr_rst_sync #(.SYNC_STAGES(SYNC_STAGES)) i_rst_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_int_n)
  );

  usr_next #(.WIDTH(WIDTH)) i_next (
    .mode_i   (mode),
    .cur_i    (data_q),
    .ser_up_i (ser_up_i),
    .ser_dn_i (ser_dn_i),
    .par_i    (par_i),
    .nxt_o    (data_d)
  );

  usr_oe i_oe (
    .mode_i  (mode),
    .oe_a_ni (oe_a_ni),
    .oe_b_ni (oe_b_ni),
    .drive_o (par_oe_o)
  );

  always_ff @(posedge clk_i or negedge rst_int_n) begin
    if (!rst_int_n) data_q <= '0;
    else            data_q <= data_d;
  end

  assign par_o     = data_q;
  assign ser_lsb_o = data_q[0];
  assign ser_msb_o = data_q[MSB];
endmodule

// File: rtl/usr_chk.sv
module usr_chk #(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [1:0]       mode_i,
  input logic             ser_up_i,
  input logic             ser_dn_i,
  input logic             oe_a_ni,
  input logic             oe_b_ni,
  input logic [WIDTH-1:0] par_i,
  input logic [WIDTH-1:0] par_o,
  input logic             par_oe_o,
  input logic             ser_lsb_o,
  input logic             ser_msb_o
);
  localparam int CW = $clog2(SYNC_STAGES + 2) + 1;
  localparam logic [CW-1:0] LIVE = CW'(SYNC_STAGES + 1);

  // Edges since reset release; saturates once updates are live.
  logic [CW-1:0] run_q;
  logic          live;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            run_q <= '0;
    else if (run_q != LIVE) run_q <= run_q + 1'b1;
  end
  assign live = (run_q == LIVE);

  AST_HOLD_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live && $past(mode_i) == 2'b00 |-> par_o == $past(par_o)); // R3
  AST_SHIFT_UP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live && $past(mode_i) == 2'b01 |-> par_o == {$past(par_o[WIDTH-2:0]), $past(ser_up_i)}); // R4
  AST_SHIFT_DN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live && $past(mode_i) == 2'b10 |-> par_o == {$past(ser_dn_i), $past(par_o[WIDTH-1:1])}); // R5
  AST_LOAD_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live && $past(mode_i) == 2'b11 |-> par_o == $past(par_i)); // R6
  AST_LOAD_RELEASES_BUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i == 2'b11 |-> !par_oe_o); // R7
  AST_DISABLE_RELEASES_BUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe_a_ni || oe_b_ni) |-> !par_oe_o); // R7
  AST_SERIAL_ENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ser_lsb_o == par_o[0] && ser_msb_o == par_o[WIDTH-1]); // R8
  AST_RELEASE_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !live |-> par_o == '0); // R2
endmodule

bind univ_shift_reg usr_chk #(.WIDTH(WIDTH), .SYNC_STAGES(SYNC_STAGES)) i_usr_chk (.*);

// File: tb/test_univ_shift_reg.sv
`timescale 1ns/1ps
module test_univ_shift_reg;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [1:0]   mode = 2'b00;
  logic         s_up = 1'b0, s_dn = 1'b0, oea = 1'b1, oeb = 1'b1;
  logic [W-1:0] pin_a = '0, pin_b = '0;
  logic [W-1:0] q_a, q_b;
  logic         oe_a, oe_b, lsb_a, msb_a, lsb_b, msb_b;
  int           n_chk = 0, n_bad = 0;
  bit           done = 1'b0;

  always #2 clk = ~clk;

  univ_shift_reg i_univ_shift_reg (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .ser_up_i(s_up), .ser_dn_i(s_dn),
    .oe_a_ni(oea), .oe_b_ni(oeb), .par_i(pin_a), .par_o(q_a), .par_oe_o(oe_a),
    .ser_lsb_o(lsb_a), .ser_msb_o(msb_a));

  // Second stage: fed from the first stage's top bit.
  univ_shift_reg i_univ_shift_reg_hi (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .ser_up_i(msb_a), .ser_dn_i(lsb_a),
    .oe_a_ni(oea), .oe_b_ni(oeb), .par_i(pin_b), .par_o(q_b), .par_oe_o(oe_b),
    .ser_lsb_o(lsb_b), .ser_msb_o(msb_b));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Inputs change and outputs are sampled 1 ns after a rising edge.
  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  initial begin
    logic [W-1:0]   exp;
    logic [2*W-1:0] chain;
    #1;
    chk("R1 reset value", {24'd0, q_a}, 32'd0);
    // R2: load ff, first two edges after release stay zero
    mode = 2'b11; pin_a = 8'hff;
    tick();
    rst_n = 1'b1;
    tick(); chk("R2 edge1", {24'd0, q_a}, 32'd0);
    tick(); chk("R2 edge2", {24'd0, q_a}, 32'd0);
    tick(); chk("R2 edge3", {24'd0, q_a}, 32'hff);

    // Sweep: every start word, mode, serial bit; enables cycle through all four.
    for (int v = 0; v < 256; v++) begin
      for (int m = 0; m < 4; m++) begin
        for (int s = 0; s < 2; s++) begin
          mode = 2'b11; pin_a = W'(v); tick();
          mode = 2'(m); s_up = s[0]; s_dn = ~s[0]; pin_a = ~W'(v);
          oea = v[0]; oeb = v[1];
          #0.5;
          chk("R7 drive enable", {31'd0, oe_a}, {31'd0, (!v[0] && !v[1] && m != 3)});
          tick();
          case (m)
            0: exp = W'(v);
            1: exp = {W'(v) << 1} | W'(s);
            2: exp = (W'(v) >> 1) | ({W{1'b0}} | (W'(~s[0]) << (W-1)));
            default: exp = ~W'(v);
          endcase
          if (m == 0) chk("R3 hold", {24'd0, q_a}, {24'd0, exp});
          else if (m == 1) chk("R4 shift up", {24'd0, q_a}, {24'd0, exp});
          else if (m == 2) chk("R5 shift down", {24'd0, q_a}, {24'd0, exp});
          else chk("R6 load", {24'd0, q_a}, {24'd0, exp});
          chk("R8 serial ends", {30'd0, msb_a, lsb_a}, {30'd0, exp[W-1], exp[0]});
          if (v[1:0] != 2'b00) chk("R9 works with bus released", {24'd0, q_a}, {24'd0, exp});
        end
      end
    end

    // R10: chained pair as a 16-bit register
    oea = 1'b0; oeb = 1'b0;
    mode = 2'b11; pin_a = 8'h5a; pin_b = 8'hc3; tick();
    chain = 16'hc35a;
    chk("R10 chain load", {16'd0, q_b, q_a}, {16'd0, chain});
    mode = 2'b01;
    for (int i = 0; i < 2 * W; i++) begin
      s_up = i[0];
      tick();
      chain = {chain[2*W-2:0], i[0]};
      chk("R10 chain shift", {16'd0, q_b, q_a}, {16'd0, chain});
      chk("R8 chain top bit", {31'd0, msb_b}, {31'd0, chain[2*W-1]});
    end

    // R1 reset mid-cycle while shifting, no clock edge needed
    mode = 2'b11; pin_a = 8'ha5; tick();
    mode = 2'b01; s_up = 1'b1;
    @(negedge clk); rst_n = 1'b0; #0.5;
    chk("R1 async clear", {24'd0, q_a}, 32'd0);
    tick(); tick();
    chk("R1 clear overrides mode", {24'd0, q_a}, 32'd0);
    rst_n = 1'b1;
    tick(); tick();
    chk("R2 still cleared", {24'd0, q_a}, 32'd0);
    tick();
    chk("R2 first shift", {24'd0, q_a}, 32'h01);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(4 * 100000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule